// File: doc/BRIEF.md
# Serial Configuration Slave with Locked Read-Back

This block is the control port of a small analog front end. A host sends it 16-bit frames over a chip select, a serial clock and one shared data line. Each frame holds a command byte and then a data byte. The block keeps a configuration byte and an offset DAC code byte. The configuration byte is decoded onto ports that set the amplifier stage enables, the filter routing, the common-mode level and the gains of the two stages. The serial pins are brought into the system clock domain, and their edges are detected there.

Read-back is locked after reset. Two key bytes written in a row to a key address unlock it. Once unlocked, a read command makes the block drive the shared data line during the data byte, through an output enable that the pad uses. In two-wire use the chip select can stay low, and frames then follow each other every 16 clocks.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset the decoded configuration outputs are all 0, `dac_code` is 0x80 and `sdio_oe` is 0.
- R2: A frame is 16 bits, most significant bit first, sampled on rising serial-clock edges. Command bit 7 is the operation (0 write, 1 read), bits 6:4 must be 0, and bits 3:0 are the address. A write to address 0x0 sets the configuration and a write to 0x1 sets the DAC code. A frame whose bits 6:4 are not all 0 changes nothing.
- R3: Configuration decode: bits 6:5 go to `amp_en[1:0]` (bit 6 enables the first stage), bit 4 to `filt_route`, bit 3 to `cm_sel`, bits 2:1 to `gain2_sel`, and bit 0 to `gain1_sel`. Bit 7 is not stored and always reads back as 0.
- R4: A write takes effect only after the 16th rising edge. If chip select rises earlier, the frame is dropped, and no register and no lock state changes.
- R5: While chip select stays low, frames run back to back every 16 clocks. A new assertion of chip select always starts a fresh frame.
- R6: In an accepted read, the block drives the line from the falling edge of the 8th clock onward. It presents the data byte MSB first and updates after each falling edge. It never drives during the command byte.
- R7: The driver is released after the 16th rising edge, or as soon as chip select rises.
- R8: While locked, a read command never asserts `sdio_oe`. While unlocked, a read returns the register contents. Reads change no register.
- R9: Read-back unlocks only when 0xFE and then 0xED are written to address 0xF in two consecutive accepted frames. Any other accepted frame between them cancels the first key.
- R10: Any other value written to address 0xF locks read-back again. Writes to other addresses leave the lock state as it is.
- R11: A read of address 0xF or of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Read data toward the pad |
| sdio_oe | output | 1 | Pad driver enable for the data line |
| amp_en | output | 2 | Stage enables, bit 1 first stage, bit 0 second stage |
| filt_route | output | 1 | Route between stages through the external filter |
| cm_sel | output | 1 | Common-mode level select |
| gain2_sel | output | 2 | Second-stage gain code |
| gain1_sel | output | 1 | First-stage gain select |
| dac_code | output | 8 | Offset DAC code |

## Verification
The hardest states to reach are the half-finished ones. These are a key sequence with the first byte accepted and the second not yet arrived, and a read that has already turned the line around when chip select is pulled. The bench reaches them with a frame task that can cut a frame after any bit count and can keep chip select low across frames. It then places an unrelated write, an aborted frame or a back-to-back frame between the two key writes, and checks both the lock state and the pad enable at the ports. Every configuration byte value is swept through write and decode, and register values are read back after the unlock.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

   localparam int CMD_W   = 8;
   localparam int DATA_W  = 8;
   localparam int FRAME_W = CMD_W + DATA_W;
   localparam int ADDR_W  = 4;
   localparam int CNT_W   = $clog2(FRAME_W);

   // command byte layout (fixed by the frame format)
   typedef struct packed {
      logic              rd;
      logic [2:0]        rsvd;
      logic [ADDR_W-1:0] addr;
   } cmd_t;

   // configuration byte layout (fixed by the decode)
   typedef struct packed {
      logic       rsvd;
      logic [1:0] amp_en;
      logic       filt_route;
      logic       cm_sel;
      logic [1:0] gain2;
      logic       gain1;
   } cfg_t;

   typedef enum logic [1:0] {
      KEY_LOCKED = 2'd0,
      KEY_ARMED  = 2'd1,
      KEY_OPEN   = 2'd2
   } key_state_e;

   function automatic logic cmd_ok(input cmd_t c);
      return c.rsvd == 3'b000;
   endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES > 4) begin : g_bad_depth
         $error("spi_cfg_sync: STAGES must be 0 to 4");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
   import spi_cfg_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cs_act,
   input  logic                          sclk_s,
   input  logic                          sdi_s,
   input  logic                          rd_allow,
   input  logic [DATA_W-1:0]             rd_data,
   output logic [ADDR_W-1:0]             rd_addr,
   output logic                          frame_done,
   output logic [CMD_W-1:0]              frame_cmd,
   output logic [DATA_W-1:0]             frame_dat,
   output logic [CNT_W-1:0]              bit_cnt,
   output logic                          sdo,
   output logic                          sdo_oe
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] TURN_BIT = CNT_W'(CMD_W);

   logic               sclk_q;
   logic               rise, fall;
   logic [FRAME_W-1:0] shreg;
   cmd_t               cmd_q;
   logic [DATA_W-1:0]  out_sh;
   logic               start_rd;

   assign rise = sclk_s & ~sclk_q;
   assign fall = ~sclk_s & sclk_q;

   // turnaround is allowed only for a well-formed read while unlocked
   assign start_rd = (bit_cnt == TURN_BIT) && cmd_q.rd && cmd_ok(cmd_q) && rd_allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q     <= 1'b0;
         bit_cnt    <= '0;
         shreg      <= '0;
         cmd_q      <= '0;
         out_sh     <= '0;
         sdo_oe     <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         sclk_q     <= sclk_s;
         frame_done <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
            sdo_oe  <= 1'b0;
         end else if (rise) begin
            shreg <= {shreg[FRAME_W-2:0], sdi_s};
            if (bit_cnt == CMD_LAST) cmd_q <= cmd_t'({shreg[CMD_W-2:0], sdi_s});
            if (bit_cnt == LAST_BIT) begin
               bit_cnt    <= '0;
               frame_done <= 1'b1;
               sdo_oe     <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else if (fall) begin
            if (start_rd) begin
               out_sh <= rd_data;
               sdo_oe <= 1'b1;
            end else if (sdo_oe) begin
               out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign rd_addr   = cmd_q.addr;
   assign frame_cmd = shreg[FRAME_W-1:DATA_W];
   assign frame_dat = shreg[DATA_W-1:0];
   assign sdo       = out_sh[DATA_W-1];

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
   import spi_cfg_pkg::*;
#(
   parameter logic [ADDR_W-1:0] CFG_ADDR   = 4'h0,
   parameter logic [ADDR_W-1:0] DAC_ADDR   = 4'h1,
   parameter logic [ADDR_W-1:0] KEY_ADDR   = 4'hF,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hFE,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hED,
   parameter logic [DATA_W-1:0] CFG_RST    = 8'h00,
   parameter logic [DATA_W-1:0] DAC_RST    = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic [CMD_W-1:0]  frame_cmd,
   input  logic [DATA_W-1:0] frame_dat,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              unlocked,
   output logic [1:0]        amp_en,
   output logic              filt_route,
   output logic              cm_sel,
   output logic [1:0]        gain2_sel,
   output logic              gain1_sel,
   output logic [DATA_W-1:0] dac_code
);

   generate
      if (CFG_ADDR == DAC_ADDR || CFG_ADDR == KEY_ADDR || DAC_ADDR == KEY_ADDR) begin : g_bad_map
         $error("spi_cfg_regs: register addresses must differ");
      end
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_key
         $error("spi_cfg_regs: key bytes must differ");
      end
   endgenerate

   cmd_t       cmd;
   logic       accept, wr;
   cfg_t       cfg_q;
   logic [DATA_W-1:0] dac_q;
   key_state_e key_q;

   assign cmd    = cmd_t'(frame_cmd);
   assign accept = frame_done && cmd_ok(cmd);
   assign wr     = accept && !cmd.rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= cfg_t'({1'b0, CFG_RST[DATA_W-2:0]});
         dac_q <= DAC_RST;
      end else if (wr) begin
         if (cmd.addr == CFG_ADDR) cfg_q <= cfg_t'({1'b0, frame_dat[DATA_W-2:0]});
         if (cmd.addr == DAC_ADDR) dac_q <= frame_dat;
      end
   end

   // key sequencer: first key arms, second key on the very next accepted frame opens
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= KEY_LOCKED;
      end else if (accept) begin
         if (wr && cmd.addr == KEY_ADDR) begin
            if (frame_dat == KEY_FIRST)
               key_q <= KEY_ARMED;
            else if (frame_dat == KEY_SECOND && key_q == KEY_ARMED)
               key_q <= KEY_OPEN;
            else
               key_q <= KEY_LOCKED;
         end else if (key_q == KEY_ARMED) begin
            key_q <= KEY_LOCKED;
         end
      end
   end

   always_comb begin
      if (rd_addr == CFG_ADDR)      rd_data = cfg_q;
      else if (rd_addr == DAC_ADDR) rd_data = dac_q;
      else                          rd_data = '0;
   end

   assign unlocked   = (key_q == KEY_OPEN);
   assign amp_en     = cfg_q.amp_en;
   assign filt_route = cfg_q.filt_route;
   assign cm_sel     = cfg_q.cm_sel;
   assign gain2_sel  = cfg_q.gain2;
   assign gain1_sel  = cfg_q.gain1;
   assign dac_code   = dac_q;

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
   import spi_cfg_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CFG_ADDR    = 4'h0,
   parameter logic [ADDR_W-1:0] DAC_ADDR    = 4'h1,
   parameter logic [ADDR_W-1:0] KEY_ADDR    = 4'hF,
   parameter logic [DATA_W-1:0] KEY_FIRST   = 8'hFE,
   parameter logic [DATA_W-1:0] KEY_SECOND  = 8'hED,
   parameter logic [DATA_W-1:0] DAC_RST     = 8'h80
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_csn,
   input  logic        spi_sclk,
   input  logic        sdio_in,
   output logic        sdio_out,
   output logic        sdio_oe,
   output logic [1:0]  amp_en,
   output logic        filt_route,
   output logic        cm_sel,
   output logic [1:0]  gain2_sel,
   output logic        gain1_sel,
   output logic [7:0]  dac_code
);

   logic [2:0]        pins_s;
   logic              cs_act;
   logic              frame_done;
   logic              unlocked;
   logic [CMD_W-1:0]  frame_cmd;
   logic [DATA_W-1:0] frame_dat;
   logic [DATA_W-1:0] rd_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [CNT_W-1:0]  bit_cnt;

   spi_cfg_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_csn, spi_sclk, sdio_in}),
      .q     (pins_s)
   );

   assign cs_act = ~pins_s[2];

   spi_cfg_frame u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .sclk_s     (pins_s[1]),
      .sdi_s      (pins_s[0]),
      .rd_allow   (unlocked),
      .rd_data    (rd_data),
      .rd_addr    (rd_addr),
      .frame_done (frame_done),
      .frame_cmd  (frame_cmd),
      .frame_dat  (frame_dat),
      .bit_cnt    (bit_cnt),
      .sdo        (sdio_out),
      .sdo_oe     (sdio_oe)
   );

   spi_cfg_regs #(
      .CFG_ADDR   (CFG_ADDR),
      .DAC_ADDR   (DAC_ADDR),
      .KEY_ADDR   (KEY_ADDR),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND),
      .CFG_RST    (8'h00),
      .DAC_RST    (DAC_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .frame_cmd  (frame_cmd),
      .frame_dat  (frame_dat),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .unlocked   (unlocked),
      .amp_en     (amp_en),
      .filt_route (filt_route),
      .cm_sel     (cm_sel),
      .gain2_sel  (gain2_sel),
      .gain1_sel  (gain1_sel),
      .dac_code   (dac_code)
   );

endmodule

// File: rtl/spi_cfg_slave_checker.sv
module spi_cfg_slave_checker #(
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_act,
   input logic          sdio_oe,
   input logic [CW-1:0] bit_cnt,
   input logic          frame_done,
   input logic          unlocked,
   input logic [7:0]    dac_code,
   input logic [1:0]    amp_en,
   input logic          gain1_sel
);

   // R8: pad driver only turns on while read-back is unlocked
   assert_oe_needs_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdio_oe) |-> unlocked);

   // R6: never driving during the command byte
   assert_no_drive_in_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> (bit_cnt >= CW'(8)));

   // R7: chip select release drops the driver on the next cycle
   assert_release_on_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !sdio_oe);

   // R4: registers only move right after a completed frame
   assert_dac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(dac_code));

   assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> ($stable(amp_en) && $stable(gain1_sel)));

   // R4: a completed frame follows the last bit of the counter
   assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_done) |-> ($past(bit_cnt) == CW'(15)));

   // R9: unlocking happens only on a completed frame
   assert_unlock_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(frame_done));

endmodule

bind spi_cfg_slave spi_cfg_slave_checker #(.CW(spi_cfg_pkg::CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_act     (cs_act),
   .sdio_oe    (sdio_oe),
   .bit_cnt    (bit_cnt),
   .frame_done (frame_done),
   .unlocked   (unlocked),
   .dac_code   (dac_code),
   .amp_en     (amp_en),
   .gain1_sel  (gain1_sel)
);

// File: tb/spi_cfg_slave_bench.sv
`timescale 1ns/1ps
module spi_cfg_slave_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_csn = 1'b1;
   logic       spi_sclk = 1'b0;
   logic       sdio_in = 1'b0;
   logic       sdio_out, sdio_oe;
   logic [1:0] amp_en, gain2_sel;
   logic       filt_route, cm_sel, gain1_sel;
   logic [7:0] dac_code;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] rd_byte;
   int         oe_data_cnt, oe_cmd_cnt;
   logic       oe_after;

   always #2.5 clk = ~clk;

   spi_cfg_slave u_spi_cfg_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_csn    (spi_csn),
      .spi_sclk   (spi_sclk),
      .sdio_in    (sdio_in),
      .sdio_out   (sdio_out),
      .sdio_oe    (sdio_oe),
      .amp_en     (amp_en),
      .filt_route (filt_route),
      .cm_sel     (cm_sel),
      .gain2_sel  (gain2_sel),
      .gain1_sel  (gain1_sel),
      .dac_code   (dac_code)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one frame of nbits bits; end_cs releases chip select afterwards
   task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nbits, input bit end_cs);
      logic [15:0] fr;
      fr = {cmd, dat};
      rd_byte = 8'h00;
      oe_data_cnt = 0;
      oe_cmd_cnt = 0;
      spi_csn = 1'b0;
      tick(4);
      for (int i = 0; i < nbits; i++) begin
         sdio_in = fr[15-i];
         tick(8);
         if (i >= 8) begin
            rd_byte[15-i] = sdio_out;
            if (sdio_oe) oe_data_cnt++;
         end else if (sdio_oe) begin
            oe_cmd_cnt++;
         end
         spi_sclk = 1'b1;
         tick(8);
         spi_sclk = 1'b0;
      end
      tick(8);
      oe_after = sdio_oe;
      if (end_cs) begin
         spi_csn = 1'b1;
         tick(6);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      xfer({4'h0, a}, d, 16, 1'b1);
   endtask

   task automatic rd(input logic [3:0] a);
      xfer({4'h8, a}, 8'h00, 16, 1'b1);
   endtask

   task automatic unlock();
      wr(4'hF, 8'hFE);
      wr(4'hF, 8'hED);
   endtask

   task automatic chk_cfg(input int v, input string req);
      logic [6:0] act, exp;
      act = {amp_en, filt_route, cm_sel, gain2_sel, gain1_sel};
      exp = {2'((v / 32) % 4), 1'((v / 16) % 2), 1'((v / 8) % 2), 2'((v / 2) % 4), 1'(v % 2)};
      chk(act == exp, req, act, exp);
   endtask

   task automatic chk_read(input logic [7:0] exp, input string req);
      chk(oe_data_cnt == 8 && oe_cmd_cnt == 0, req, oe_data_cnt, 8);
      chk(rd_byte == exp, req, rd_byte, exp);
      chk(oe_after == 1'b0, "R7 release after 16th edge", oe_after, 0);
   endtask

   task automatic chk_no_drive(input string req);
      chk(oe_data_cnt == 0 && oe_cmd_cnt == 0, req, oe_data_cnt + oe_cmd_cnt, 0);
   endtask

   initial begin
      tick(10);
      rst_n = 1'b1;
      tick(5);

      // R1 reset state
      chk_cfg(0, "R1 reset config");
      chk(dac_code == 8'h80, "R1 reset dac", dac_code, 8'h80);
      chk(sdio_oe == 1'b0, "R1 reset oe", sdio_oe, 0);

      // R8 locked read: no drive
      rd(4'h1);
      chk_no_drive("R8 locked read");

      // R2 R3 full sweep of configuration writes
      for (int v = 0; v < 256; v++) begin
         wr(4'h0, 8'(v));
         chk_cfg(v, "R3 decode sweep");
      end

      // R2 dac writes
      for (int v = 0; v < 256; v += 17) begin
         wr(4'h1, 8'(v));
         chk(dac_code == 8'(v), "R2 dac write", dac_code, v);
      end

      // R2 reserved command bits set: ignored
      wr(4'h1, 8'h3C);
      xfer(8'h31, 8'h55, 16, 1'b1);
      chk(dac_code == 8'h3C, "R2 reserved bits ignored", dac_code, 8'h3C);

      // R9 unlock and read-back (R3 bit 7 reads 0, R6 MSB first)
      wr(4'h0, 8'hFF);
      unlock();
      rd(4'h0);
      chk_read(8'h7F, "R3 R6 read cfg");
      foreach (rd_byte[k]) begin end
      for (int v = 1; v < 256; v = v * 3) begin
         wr(4'h1, 8'(v));
         rd(4'h1);
         chk_read(8'(v), "R6 R8 read dac");
      end
      // R11 unmapped and key address read zero
      rd(4'hF);
      chk_read(8'h00, "R11 read key addr");
      rd(4'h7);
      chk_read(8'h00, "R11 read unmapped");
      // R8 reads change nothing
      chk(dac_code == 8'(243), "R8 reads no side effect", dac_code, 243);

      // R10 other-address writes keep mode
      wr(4'h0, 8'h2A);
      rd(4'h0);
      chk_read(8'h2A, "R10 mode kept");
      // R10 other key value relocks
      wr(4'hF, 8'h12);
      rd(4'h0);
      chk_no_drive("R10 relock");

      // R9 intervening accepted frame cancels first key
      wr(4'hF, 8'hFE);
      wr(4'h1, 8'h44);
      wr(4'hF, 8'hED);
      rd(4'h1);
      chk_no_drive("R9 intervening write");
      // R9 second key alone does nothing
      wr(4'hF, 8'hED);
      rd(4'h1);
      chk_no_drive("R9 second key alone");
      // R4 aborted second key leaves it armed? no change: next full key opens
      wr(4'hF, 8'hFE);
      xfer(8'h0F, 8'h12, 12, 1'b1);
      wr(4'hF, 8'hED);
      rd(4'h1);
      chk_read(8'h44, "R4 R9 aborted frame no effect");

      // R4 aborted writes
      xfer(8'h01, 8'h99, 10, 1'b1);
      chk(dac_code == 8'h44, "R4 abort at 10 bits", dac_code, 8'h44);
      xfer(8'h01, 8'h99, 15, 1'b1);
      chk(dac_code == 8'h44, "R4 abort at 15 bits", dac_code, 8'h44);
      xfer(8'h00, 8'h11, 8, 1'b1);
      chk_cfg(8'h2A, "R4 abort cfg");

      // R7 chip select pulled during read data
      xfer(8'h81, 8'h00, 11, 1'b1);
      chk(sdio_oe == 1'b0, "R7 release on cs rise", sdio_oe, 0);
      chk(oe_data_cnt == 3, "R6 drive started at turnaround", oe_data_cnt, 3);

      // R5 restart after partial frame, then back-to-back frames with cs low
      xfer(8'h01, 8'hFF, 5, 1'b1);
      xfer(8'h01, 8'h11, 16, 1'b0);
      xfer(8'h00, 8'h25, 16, 1'b0);
      xfer(8'h81, 8'h00, 16, 1'b0);
      chk(dac_code == 8'h11, "R5 back to back first", dac_code, 8'h11);
      chk_cfg(8'h25, "R5 back to back second");
      chk_read(8'h11, "R5 back to back read");
      spi_csn = 1'b1;
      tick(6);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule